// File: doc/BRIEF.md
# Accumulator Processor Memory-Instruction Sequencer

This block is the control sequencer and register set of a small 16-bit single-accumulator processor. A step counter drives a fixed list of register transfers. Each instruction starts at step 0. The sequencer fetches the instruction word and decodes it. If the word asks for it, the sequencer resolves one level of indirect addressing. It then executes one of seven memory-operand instructions. The block owns the program counter, address register, instruction register, data register, accumulator and carry flag.

The block drives a word-addressed synchronous memory through an address port, a write-data port, a write-enable port and a read-data port. The memory must return the read word one clock after it sees the address, and it must write on the clock edge where write-enable is high. The memory itself sits outside the block, so a bench or a system can preload it.

The `run` input gates only the start of an instruction. While it is low, the block waits at step 0. A one-cycle `retire` pulse marks each completed instruction. The accumulator, program counter and carry flag are brought out for observation.

Top module: `acs_seq`

## Requirements
- R1: After synchronous reset the accumulator, program counter and carry flag are 0, and both `mem_we` and `retire` are low.
- R2: While the step counter is at step 0 and `run` is low, no register changes and no memory write occurs. `retire` pulses for one cycle as each instruction ends, and the step counter is then back at step 0.
- R3: The fetch loads the address register from the program counter, reads the instruction word and increments the program counter by one, with 12-bit wrap. The instruction word has the indirect flag in bit 15, the opcode in bits 14:12 and the operand address in bits 11:0.
- R4: When bit 15 is 1 and the opcode is not 7, the operand address is replaced by bits 11:0 of the memory word at that address before execution, and the upper four bits of that pointer are ignored. Indirection adds exactly 2 cycles.
- R5: Opcode 0 (AND) sets the accumulator to the bitwise AND of the accumulator and the operand, leaves the carry flag unchanged, and takes 7 cycles when direct.
- R6: Opcode 1 (ADD) sets the accumulator to the low 16 bits of accumulator plus operand and puts the carry-out in the carry flag. It takes 7 cycles when direct.
- R7: Opcode 2 (LDA) copies the operand into the accumulator. Opcode 3 (STA) writes the accumulator to the operand address. Each takes 7 cycles when direct.
- R8: Opcode 4 (BUN) sets the program counter to the operand address. It takes 5 cycles when direct.
- R9: Opcode 5 (BSA) writes the already-incremented program counter, zero-extended, to the operand address and sets the program counter to that address plus 1. It takes 6 cycles when direct.
- R10: Opcode 6 (ISZ) writes the operand plus 1 (mod 2^16) back to the operand address. It increments the program counter once more when the written value is 0, and takes 9 cycles when direct.
- R11: Opcode 7 leaves the accumulator, carry flag and memory unchanged and performs no indirect read, even with bit 15 set. It retires 4 cycles after it starts.
- R12: `mem_we` is high for exactly one cycle per STA, BSA or ISZ and never for the other opcodes. The memory address port always shows the address register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows a new instruction to start at step 0 |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable, one cycle per store |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| ac_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| e_out | output | 1 | Carry flag |
| retire | output | 1 | One-cycle pulse at the end of each instruction |

## Verification
The bench sweeps AND and ADD over an 8-by-8 grid of operands that includes 0 and 0xFFFF. A wrong carry path shows up as a bad carry flag when 0xFFFF plus a nonzero value wraps. ISZ is run on values that include 0xFFFF and 0xFFFE, which exposes a skip taken on the wrong value or a write-back of the stale operand. Indirect operands use pointers with their upper bits set, so a design that failed to mask the pointer, or that dereferenced on opcode 7, would read the wrong word or miss the 4-cycle retire. A BSA call followed by an indirect return checks that the stored return address is the incremented program counter. Cycle counts are compared for every opcode, so an added or missing step is reported.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int OPC_W  = 3;
  localparam int STEP_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_AND = 3'd0,
    OPC_ADD = 3'd1,
    OPC_LDA = 3'd2,
    OPC_STA = 3'd3,
    OPC_BUN = 3'd4,
    OPC_BSA = 3'd5,
    OPC_ISZ = 3'd6,
    OPC_NMR = 3'd7
  } opc_e;
endpackage

// File: rtl/acs_stepctr.sv
module acs_stepctr #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          clr,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  output logic [SW-1:0] step_q
);
  // clear wins over reload, reload wins over advance
  always_ff @(posedge clk) begin
    if (rst)       step_q <= '0;
    else if (clr)  step_q <= '0;
    else if (load) step_q <= load_val;
    else if (!hold) step_q <= step_q + 1'b1;
  end
endmodule

// File: rtl/acs_opdec.sv
module acs_opdec #(
  parameter int OW = 3
) (
  input  logic [OW-1:0]     opc,
  output logic [(1<<OW)-1:0] dec
);
  localparam int NCODE = 1 << OW;
  for (genvar i = 0; i < NCODE; i++) begin : g_dec
    assign dec[i] = (opc == OW'(i));
  end
endmodule

// File: rtl/acs_alu.sv
module acs_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W:0]   sum_o,
  output logic [W-1:0] inc_o
);
  assign and_o = a & b;
  assign sum_o = {1'b0, a} + {1'b0, b};
  assign inc_o = b + 1'b1;
endmodule

// File: rtl/acs_seq.sv
module acs_seq
  import acs_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] ac_out,
  output logic [AW-1:0] pc_out,
  output logic          e_out,
  output logic          retire
);
  localparam int IND_BIT = DW - 1;
  localparam int OPC_LSB = IND_BIT - OPC_W;
  localparam int NCODE   = 1 << OPC_W;
  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] S6 = STEP_W'(6);
  localparam logic [STEP_W-1:0] S7 = STEP_W'(7);
  localparam logic [STEP_W-1:0] S8 = STEP_W'(8);

  logic [AW-1:0]    pc_q, ar_q;
  logic [DW-1:0]    ir_q, dr_q, ac_q, wdata_q;
  logic             e_q, we_q, retire_q;
  logic [STEP_W-1:0] step_q;
  logic [OPC_W-1:0] opc_w;
  logic [NCODE-1:0] d;
  logic             ind_w, dir;
  logic             s0, s2, s3, s4, s5, s6, s7, s8;
  logic             hold, done, resolve;
  logic [DW-1:0]    and_r, inc_r;
  logic [DW:0]      sum_r;

  assign opc_w = ir_q[OPC_LSB +: OPC_W];
  assign ind_w = ir_q[IND_BIT];
  assign dir   = ~ind_w;

  assign s0 = (step_q == S0);
  assign s2 = (step_q == S2);
  assign s3 = (step_q == S3);
  assign s4 = (step_q == S4);
  assign s5 = (step_q == S5);
  assign s6 = (step_q == S6);
  assign s7 = (step_q == S7);
  assign s8 = (step_q == S8);

  acs_stepctr #(.SW(STEP_W)) u_step (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .clr      (done),
    .load     (resolve),
    .load_val (S4),
    .step_q   (step_q)
  );

  acs_opdec #(.OW(OPC_W)) u_dec (
    .opc (opc_w),
    .dec (d)
  );

  acs_alu #(.W(DW)) u_alu (
    .a     (ac_q),
    .b     (dr_q),
    .and_o (and_r),
    .sum_o (sum_r),
    .inc_o (inc_r)
  );

  // control: idle gate, indirect resolution and end of instruction
  always_comb begin
    hold    = s0 & ~run;
    resolve = s5 & ind_w & ~d[OPC_NMR];
    done    = (s3 & d[OPC_NMR])
            | (s4 & dir & d[OPC_BUN])
            | (s5 & dir & d[OPC_BSA])
            | (s6 & dir & (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA] | d[OPC_STA]))
            | (s8 & d[OPC_ISZ]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ar_q     <= '0;
      ir_q     <= '0;
      dr_q     <= '0;
      ac_q     <= '0;
      e_q      <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      retire_q <= 1'b0;
    end else begin
      retire_q <= done;
      we_q     <= (s4 & dir & d[OPC_BSA]) | (s5 & dir & d[OPC_STA]) | (s7 & d[OPC_ISZ]);

      // fetch
      if (s0 & run) ar_q <= pc_q;
      if (s2) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + 1'b1;
      end
      // address field into AR
      if (s3) ar_q <= ir_q[AW-1:0];

      // step 4: branch-type instructions act without an operand read
      if (s4 & dir & d[OPC_BUN]) pc_q <= ar_q;
      if (s4 & dir & d[OPC_BSA]) wdata_q <= {{(DW-AW){1'b0}}, pc_q};

      // step 5: indirect pointer or operand capture
      if (resolve) begin
        ar_q          <= mem_rdata[AW-1:0];
        ir_q[IND_BIT] <= 1'b0;
      end
      if (s5 & dir & (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA] | d[OPC_ISZ]))
        dr_q <= mem_rdata;
      if (s5 & dir & d[OPC_STA]) wdata_q <= ac_q;
      if (s5 & dir & d[OPC_BSA]) pc_q <= ar_q + 1'b1;

      // step 6: accumulator updates and ISZ increment
      if (s6 & d[OPC_AND]) ac_q <= and_r;
      if (s6 & d[OPC_ADD]) {e_q, ac_q} <= sum_r;
      if (s6 & d[OPC_LDA]) ac_q <= dr_q;
      if (s6 & d[OPC_ISZ]) dr_q <= inc_r;

      // step 7: ISZ write-back data and skip
      if (s7 & d[OPC_ISZ]) begin
        wdata_q <= dr_q;
        if (dr_q == '0) pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
  assign ac_out    = ac_q;
  assign pc_out    = pc_q;
  assign e_out     = e_q;
  assign retire    = retire_q;
endmodule

// File: rtl/acs_seq_chk.sv
module acs_seq_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        run,
  input logic [acs_pkg::STEP_W-1:0]  step,
  input logic [acs_pkg::OPC_W-1:0]   opc,
  input logic                        ind,
  input logic                        mem_we,
  input logic                        retire,
  input logic [AW-1:0]               pc,
  input logic [DW-1:0]               ac,
  input logic                        e
);
  // R2: idle at step 0 holds everything
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (step == 0 && !run) |=> (step == 0 && $stable(pc) && $stable(ac) && $stable(e) && !mem_we));

  // R2: retire lands on an instruction boundary
  assert_retire_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    retire |-> (step == 0));

  // R3: fetch step increments the program counter
  assert_fetch_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (step == 2) |=> (pc == $past(pc) + 1'b1));

  // R4: indirect resolution returns to step 4 with the flag cleared
  assert_indirect_loop_R4: assert property (@(posedge clk) disable iff (rst)
    (step == 5 && ind && opc != 3'd7) |=> (step == 4 && !ind));

  // R11: opcode 7 retires from step 3 without touching AC or E
  assert_nonmem_noop_R11: assert property (@(posedge clk) disable iff (rst)
    (step == 3 && opc == 3'd7) |=> (retire && $stable(ac) && $stable(e)));

  // R12: writes only in the store slots of STA, BSA and ISZ
  assert_we_slot_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((step == 5 && opc == 3'd5) || (step == 6 && opc == 3'd3) || (step == 8 && opc == 3'd6)));

  // R12: write enable is a single-cycle pulse
  assert_we_single_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind acs_seq acs_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .run    (run),
  .step   (step_q),
  .opc    (opc_w),
  .ind    (ind_w),
  .mem_we (mem_we),
  .retire (retire),
  .pc     (pc_q),
  .ac     (ac_q),
  .e      (e_q)
);

// File: tb/acs_seq_test.sv
module acs_seq_test;
  localparam int CLK_P = 10;

  logic        clk, rst, run;
  logic [11:0] mem_addr, pc_out;
  logic [15:0] mem_wdata, mem_rdata, ac_out;
  logic        mem_we, e_out, retire;
  logic [15:0] mem [0:4095];

  int checks = 0;
  int errors = 0;
  int we_cnt;

  acs_seq uut (
    .clk(clk), .rst(rst), .run(run),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .ac_out(ac_out), .pc_out(pc_out),
    .e_out(e_out), .retire(retire)
  );

  // synchronous memory, read-before-write, one cycle latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // start at a negedge in step 0, run until n instructions retire
  task automatic run_n(input int n, output int cyc);
    int got = 0;
    cyc = 0;
    we_cnt = 0;
    run = 1'b1;
    while (got < n) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (mem_we) we_cnt++;
      if (retire) got++;
    end
    run = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int i);
    int v;
    if (i == 0) return 16'h0000;
    if (i == 7) return 16'hFFFF;
    v = i * 9029 + 257;
    return v[15:0];
  endfunction

  initial begin
    int c;
    int s;
    logic [15:0] a, b, k, kp;

    // R1 reset state
    rst = 1'b1;
    run = 1'b0;
    do_reset();
    chk("R1 ac", 32'(ac_out), 32'h0);
    chk("R1 pc", 32'(pc_out), 32'h0);
    chk("R1 e", 32'(e_out), 32'h0);
    chk("R1 we", 32'(mem_we), 32'h0);
    chk("R1 retire", 32'(retire), 32'h0);

    // R6 ADD sweep, R5 AND sweep
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          a = pat(i);
          b = pat(j);
          do_reset();
          mem[0] = 16'h2100;
          mem[1] = (op == 0) ? 16'h1101 : 16'h0101;
          mem[12'h100] = a;
          mem[12'h101] = b;
          run_n(2, c);
          chk("R3 pc after two", 32'(pc_out), 32'h2);
          if (op == 0) begin
            s = int'(a) + int'(b);
            chk("R6 add sum", 32'(ac_out), 32'(s[15:0]));
            chk("R6 add carry", 32'(e_out), 32'(s[16]));
            chk("R6 cycles", 32'(c), 32'd14);
          end else begin
            chk("R5 and result", 32'(ac_out), 32'(a & b));
            chk("R5 carry kept", 32'(e_out), 32'h0);
            chk("R5 cycles", 32'(c), 32'd14);
          end
          chk("R12 no write", 32'(we_cnt), 32'h0);
        end
      end
    end

    // R7 LDA then STA, R2 idle hold
    do_reset();
    mem[0] = 16'h2100;
    mem[1] = 16'h3200;
    mem[12'h100] = 16'h5A3C;
    run_n(1, c);
    chk("R7 lda", 32'(ac_out), 32'h5A3C);
    chk("R7 lda cycles", 32'(c), 32'd7);
    run_n(1, c);
    chk("R7 sta mem", 32'(mem[12'h200]), 32'h5A3C);
    chk("R7 sta cycles", 32'(c), 32'd7);
    chk("R12 sta one write", 32'(we_cnt), 32'h1);
    repeat (10) @(negedge clk);
    chk("R2 hold pc", 32'(pc_out), 32'h2);
    chk("R2 hold ac", 32'(ac_out), 32'h5A3C);
    chk("R2 hold mem", 32'(mem[12'h200]), 32'h5A3C);
    chk("R2 hold we", 32'(mem_we), 32'h0);

    // R8 BUN
    do_reset();
    mem[0] = 16'h4050;
    run_n(1, c);
    chk("R8 bun pc", 32'(pc_out), 32'h050);
    chk("R8 bun cycles", 32'(c), 32'd5);

    // R9 BSA call, R4 indirect return
    do_reset();
    mem[0] = 16'h5080;
    mem[1] = 16'h10A1;
    mem[12'h081] = 16'h20A0;
    mem[12'h082] = 16'hC080;
    mem[12'h0A0] = 16'h0007;
    mem[12'h0A1] = 16'h0005;
    run_n(1, c);
    chk("R9 bsa pc", 32'(pc_out), 32'h081);
    chk("R9 bsa stored", 32'(mem[12'h080]), 32'h0001);
    chk("R9 bsa cycles", 32'(c), 32'd6);
    chk("R12 bsa one write", 32'(we_cnt), 32'h1);
    run_n(1, c);
    run_n(1, c);
    chk("R4 indirect bun pc", 32'(pc_out), 32'h001);
    chk("R4 indirect bun cycles", 32'(c), 32'd7);
    run_n(1, c);
    chk("R9 return ac", 32'(ac_out), 32'h000C);

    // R4 indirect LDA and STA with high pointer bits
    do_reset();
    mem[0] = 16'hA030;
    mem[1] = 16'hB031;
    mem[12'h030] = 16'hF345;
    mem[12'h031] = 16'h7400;
    mem[12'h345] = 16'hBEEF;
    run_n(1, c);
    chk("R4 indirect lda", 32'(ac_out), 32'hBEEF);
    chk("R4 indirect lda cycles", 32'(c), 32'd9);
    run_n(1, c);
    chk("R4 indirect sta", 32'(mem[12'h400]), 32'hBEEF);
    chk("R4 pointer kept", 32'(mem[12'h031]), 32'h7400);

    // R10 ISZ sweep
    for (int i = 0; i < 9; i++) begin
      k = (i == 8) ? 16'hFFFE : pat(i);
      kp = k + 16'h1;
      do_reset();
      mem[0] = 16'h6090;
      mem[1] = 16'h4010;
      mem[2] = 16'h4020;
      mem[12'h090] = k;
      run_n(1, c);
      chk("R10 isz cycles", 32'(c), 32'd9);
      chk("R10 isz one write", 32'(we_cnt), 32'h1);
      chk("R10 isz mem", 32'(mem[12'h090]), 32'(kp));
      run_n(1, c);
      chk("R10 isz skip", 32'(pc_out), (kp == 16'h0) ? 32'h020 : 32'h010);
    end

    // R11 opcode 7, plain and with indirect flag
    do_reset();
    mem[0] = 16'h2100;
    mem[1] = 16'h1101;
    mem[2] = 16'hF7FF;
    mem[3] = 16'h7123;
    mem[12'h100] = 16'hFFFF;
    mem[12'h101] = 16'h0001;
    run_n(2, c);
    chk("R6 wrap carry", 32'(e_out), 32'h1);
    run_n(1, c);
    chk("R11 cycles", 32'(c), 32'd4);
    chk("R11 no write", 32'(we_cnt), 32'h0);
    run_n(1, c);
    chk("R11 ac kept", 32'(ac_out), 32'h0000);
    chk("R11 e kept", 32'(e_out), 32'h1);
    chk("R11 pc", 32'(pc_out), 32'h004);
    chk("R11 mem kept", 32'(mem[12'h7FF]), 32'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule